// File: doc/BRIEF.md
# Dual-Modulus Prescaler Sequencing Counter

This block sits after a two-modulus prescaler and runs on the prescaler's output clock. Each division sequence has two parts. In the first part a single 12-bit counter counts down for N1 cycles, and the prescaler is held on its lower ratio. In the second part the same counter counts up for N2 cycles, and the prescaler is switched to its higher ratio. In the last cycle of the sequence the block raises a one-cycle pulse toward the phase comparator, then begins the next sequence. One counter therefore handles both the total division and the prescaler control, so no separate swallow counter is needed.

Two modulus-control outputs are provided, one the complement of the other. A strobe from a fractional accumulator can be applied at any time. It arranges for exactly one of the down-count cycles in the following sequence to run at the higher ratio, which interpolates a fraction of a comparison step. The two programming words are sampled only when a sequence starts, so the loop can be retuned without breaking a sequence in progress.

Top module: `dualmod_seq_ctr`

## Requirements
- R1: During the down phase, `mod_hi` is 1 for N1 consecutive cycles, which are the first N1 cycles of each sequence.
- R2: During the up phase, `mod_hi` is 0 for the N2 cycles that follow the down phase.
- R3: `cmp_pulse` is high for exactly one cycle per sequence. That cycle is the last cycle of the sequence, so pulses are N1+N2 cycles apart, and the next cycle begins a new down phase.
- R4: A programmed `n1_word` of 0, 1 or 2 behaves as N1 = 3.
- R5: A programmed `n2_word` of 0 behaves as N2 = 256.
- R6: The counter is 12 bits wide, so N1 may be as large as 4095.
- R7: `n1_word` and `n2_word` are sampled only at the clock edge that ends a sequence (the pulse cycle) and at reset. A change in the middle of a sequence does not alter that sequence.
- R8: `mod_lo` is always the complement of `mod_hi`.
- R9: A `frac_ovf` strobe during a sequence makes the last down-phase cycle of the next sequence run with `mod_hi` = 0. The sequence length does not change, and the sequence after that is unaffected.
- R10: Any number of strobes within one sequence cause only one swapped cycle. A strobe given in the pulse cycle applies to the sequence that begins right after that pulse.
- R11: Reset is synchronous and active low. The cycle after reset is released is the first cycle of a fresh sequence built from the current words, with `mod_hi` = 1 and `cmp_pulse` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Prescaler output clock |
| rst_n | input | 1 | Synchronous active-low reset |
| n1_word | input | 12 | Down-phase cycle count N1 (values below 3 clamp to 3) |
| n2_word | input | 8 | Up-phase cycle count N2 (0 means 256) |
| frac_ovf | input | 1 | Fractional overflow strobe |
| mod_hi | output | 1 | Modulus control, high selects the lower prescaler ratio |
| mod_lo | output | 1 | Complement of `mod_hi` |
| cmp_pulse | output | 1 | One-cycle pulse to the phase comparator at the end of each sequence |

## Verification
Two events can fall on the same edge: the end-of-sequence reload, which takes new words and starts a down phase, and the arrival of a fractional strobe. Both can also coincide with a change to the programming words. The bench provokes the first case by raising `frac_ovf` in exactly the cycle where `cmp_pulse` is seen. It passes only if the very next sequence loses one high cycle while keeping its full length. A separate case changes the words one cycle into a sequence and checks that the running sequence keeps its old length and high count.

// File: rtl/dualmod_seq_ctr.sv
module dualmod_seq_ctr #(
  parameter int CW     = 12,
  parameter int N2W    = 8,
  parameter int N1_MIN = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] n1_word,
  input  logic [N2W-1:0] n2_word,
  input  logic          frac_ovf,
  output logic          mod_hi,
  output logic          mod_lo,
  output logic          cmp_pulse
);

  localparam logic [CW-1:0]  N1_FLOOR = CW'(N1_MIN);
  localparam logic [N2W:0]   N2_WRAP  = (N2W+1)'(1 << N2W);

  logic [CW-1:0] n1_eff, n1_lat, cnt;
  logic [N2W:0]  n2_eff, n2_lat;
  logic          up_ph, frac_pend, frac_act;

  assign n1_eff = (n1_word < N1_FLOOR) ? N1_FLOOR : n1_word;
  assign n2_eff = (n2_word == '0) ? N2_WRAP : {1'b0, n2_word};

  assign cmp_pulse = up_ph && (cnt == CW'(n2_lat));
  assign mod_hi    = !up_ph && !(frac_act && cnt == '0);
  assign mod_lo    = !mod_hi;

  always_ff @(posedge clk) begin
    if (!rst_n || cmp_pulse) begin
      up_ph     <= 1'b0;
      cnt       <= n1_eff - CW'(1);
      n1_lat    <= n1_eff;
      n2_lat    <= n2_eff;
      frac_act  <= rst_n && (frac_pend || frac_ovf);
      frac_pend <= 1'b0;
    end else begin
      if (frac_ovf) frac_pend <= 1'b1;
      if (!up_ph) begin
        if (cnt == '0) begin
          up_ph <= 1'b1;
          cnt   <= CW'(1);
        end else begin
          cnt <= cnt - CW'(1);
        end
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  a_r4_clamp: assert property (@(posedge clk) disable iff (!rst_n)
    n1_lat >= N1_FLOOR);

  a_r1_down_bound: assert property (@(posedge clk) disable iff (!rst_n)
    !up_ph |-> cnt < n1_lat);

  a_r2_up_low: assert property (@(posedge clk) disable iff (!rst_n)
    (up_ph && !cmp_pulse) |=> !mod_hi);

  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_pulse |=> (!cmp_pulse && mod_hi));

  a_r7_hold_words: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_pulse |=> ($stable(n1_lat) && $stable(n2_lat)));

endmodule

// File: tb/sim_dualmod_seq_ctr.sv
module sim_dualmod_seq_ctr;
  localparam int CLK_NS = 10;
  localparam int NV = 8;
  localparam int V_N1[NV]  = '{5, 3, 1, 0, 4095, 2, 100, 3};
  localparam int V_N2[NV]  = '{10, 1, 4, 0, 1, 0, 37, 255};
  localparam int V_PER[NV] = '{15, 4, 7, 259, 4096, 259, 137, 258};
  localparam int V_HI[NV]  = '{5, 3, 3, 3, 4095, 3, 100, 3};

  logic clk = 0, rst_n = 0, frac_ovf = 0;
  logic [11:0] n1_word = 12'd5;
  logic [7:0]  n2_word = 8'd3;
  logic mod_hi, mod_lo, cmp_pulse;
  int checks = 0, fails = 0, comp_err = 0;

  dualmod_seq_ctr u0 (.clk(clk), .rst_n(rst_n), .n1_word(n1_word), .n2_word(n2_word),
    .frac_ovf(frac_ovf), .mod_hi(mod_hi), .mod_lo(mod_lo), .cmp_pulse(cmp_pulse));

  always #(CLK_NS/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic sync_pulse();
    do @(negedge clk); while (!cmp_pulse);
  endtask

  task automatic run_seq(input int s1, input int s2, output int per, output int hi);
    int k = 0;
    hi = 0;
    forever begin
      @(negedge clk);
      k++;
      frac_ovf = (k == s1) || (k == s2);
      if (mod_lo !== ~mod_hi) comp_err++;
      if (mod_hi) hi++;
      if (cmp_pulse) break;
    end
    per = k;
  endtask

  initial begin
    #(CLK_NS * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int per, hi;
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R11 mod_hi after reset", mod_hi, 1);
    chk("R11 pulse after reset", cmp_pulse, 0);
    run_seq(0, 0, per, hi);
    chk("R11 first sequence rest length", per, 7);
    chk("R11 first sequence rest highs", hi, 4);

    for (int i = 0; i < NV; i++) begin
      n1_word = 12'(V_N1[i]);
      n2_word = 8'(V_N2[i]);
      sync_pulse();
      run_seq(0, 0, per, hi);
      chk("R3/R4/R5/R6 period", per, V_PER[i]);
      chk("R1/R2 high count", hi, V_HI[i]);
    end

    n1_word = 12'd8; n2_word = 8'd4;
    sync_pulse();
    @(negedge clk);
    n1_word = 12'd20; n2_word = 8'd10;
    run_seq(0, 0, per, hi);
    chk("R7 running sequence rest length", per, 11);
    chk("R7 running sequence rest highs", hi, 7);
    run_seq(0, 0, per, hi);
    chk("R7 new words length", per, 30);
    chk("R7 new words highs", hi, 20);

    n1_word = 12'd6; n2_word = 8'd4;
    sync_pulse();
    run_seq(3, 0, per, hi);
    chk("R9 strobe sequence highs", hi, 6);
    run_seq(0, 0, per, hi);
    chk("R9 swapped sequence length", per, 10);
    chk("R9 swapped sequence highs", hi, 5);
    run_seq(0, 0, per, hi);
    chk("R9 following sequence highs", hi, 6);
    run_seq(10, 0, per, hi);
    chk("R10 pulse-cycle strobe own highs", hi, 6);
    run_seq(0, 0, per, hi);
    chk("R10 pulse-cycle strobe next highs", hi, 5);
    run_seq(2, 7, per, hi);
    chk("R10 double strobe own highs", hi, 6);
    run_seq(0, 0, per, hi);
    chk("R10 double strobe one swap", hi, 5);
    run_seq(0, 0, per, hi);
    chk("R10 double strobe no carry", hi, 6);
    chk("R8 complement mismatches", comp_err, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule